// File: doc/BRIEF.md
# Johnson Decade Counter

A divide-by-ten counter whose count lives in a five-stage twisted-ring (Johnson) shift register. Each rising clock edge shifts the ring by one place, feeding the inverse of the last stage back into the first, so the register walks through ten distinct patterns before repeating. Ten decoded outputs are produced from the ring, exactly one of them high per count. Each decoded output is formed from only two neighbouring ring stages. A carry output with a 50% duty cycle runs at one tenth of the clock rate.

A hold input, when high, freezes the count. The carry rises on the edge where the count wraps from nine back to zero. This lets one stage's carry act as the clock of the next stage, or lets the decoded outputs gate a following stage's hold, so that stages can be chained into larger dividers. An asynchronous, active-high clear returns the ring to its all-zero pattern and, while it is asserted, forces every decoded output low.

The ring recognises any of the 22 five-bit patterns outside its ten-state cycle. On the next clock edge it replaces such a pattern with the count-zero pattern, so a disturbed register rejoins the cycle at once. There is no data stream through the block: all pins are plain control and status lines.

Top module: `johnson_decade`

## Requirements
- R1: With clear and hold low, each rising clock edge advances the count by one. Decoded output bit k+1 replaces bit k, and bit 9 is followed by bit 0. Bit k of `dec_o` is high for count k.
- R2: Whenever clear is low and the ring holds a legal pattern, exactly one bit of `dec_o` is high.
- R3: Over any ten consecutive advancing clock edges, every bit of `dec_o` is high for exactly one clock period.
- R4: `carry_o` is high for counts 0 to 4 and low for counts 5 to 9. It therefore rises on the edge where the count wraps from 9 to 0.
- R5: While hold is high at a rising clock edge, the count does not change and `dec_o` and `carry_o` keep their values.
- R6: Raising clear forces every bit of `dec_o` low at once, without waiting for a clock edge. The outputs stay low for as long as clear is high, whatever the clock and hold do, and `carry_o` reads high in this time.
- R7: When clear falls, count 0 is presented at once: `dec_o` equals 10'b0000000001 and `carry_o` is high. Counting resumes from there on the next advancing edge.
- R8: If the ring holds any pattern outside its ten-state cycle, the next rising clock edge loads the count-zero pattern, whether or not hold is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; the count changes on its rising edge |
| clear | input | 1 | Asynchronous active-high clear; forces decoded outputs low |
| hold | input | 1 | Active-high count inhibit, sampled at the rising clock edge |
| dec_o | output | 10 | One-hot decoded count, bit k high for count k |
| carry_o | output | 1 | Divide-by-ten carry, high for counts 0 to 4 |

## Verification
Counting, hold and illegal-pattern correction all act on the rising edge that samples hold. The bench updates its expected count just after that edge and compares `dec_o` and `carry_o` at the following falling edge, half a period later. Clear acts without a clock, so its assertion and release are checked two nanoseconds after the pin changes, in the middle of a clock phase. For the correction, an illegal pattern is forced into the ring between edges, and the expected count is zero at the falling edge after the next rising edge.

// File: rtl/johnson_decade_pkg.sv
`timescale 1ns/1ps
package johnson_decade_pkg;

  // What the ring does at the coming clock edge.
  typedef enum logic [1:0] {
    RING_HOLD   = 2'd0,
    RING_SHIFT  = 2'd1,
    RING_RESYNC = 2'd2
  } ring_op_e;

endpackage

// File: rtl/johnson_ring.sv
`timescale 1ns/1ps
module johnson_ring
  import johnson_decade_pkg::*;
#(
  parameter int STAGES = 5
) (
  input  logic              clk,
  input  logic              clear,
  input  logic              hold,
  output logic [STAGES-1:0] state_o,
  output logic              legal_o
);

  localparam logic [STAGES-1:0] ONE = STAGES'(1);

  logic [STAGES-1:0] state_q;
  logic [STAGES-1:0] state_d;
  logic [STAGES-1:0] inv_state;
  logic [STAGES-1:0] shifted;
  ring_op_e          op;

  // A legal pattern is one run of ones that either starts at stage 0
  // (filling) or ends at the last stage (draining).
  always_comb begin
    inv_state = ~state_q;
    legal_o   = ((state_q & (state_q + ONE)) == '0) ||
                ((inv_state & (inv_state + ONE)) == '0);
  end

  always_comb begin
    shifted = {state_q[STAGES-2:0], ~state_q[STAGES-1]};
    if (!legal_o)  op = RING_RESYNC;
    else if (hold) op = RING_HOLD;
    else           op = RING_SHIFT;
  end

  always_comb begin
    unique case (op)
      RING_SHIFT:  state_d = shifted;
      RING_HOLD:   state_d = state_q;
      default:     state_d = '0;
    endcase
  end

  always_ff @(posedge clk or posedge clear) begin
    if (clear) state_q <= '0;
    else       state_q <= state_d;
  end

  assign state_o = state_q;

  // R5: a held legal count stays put across the edge
  assert_hold_keeps_R5: assert property (@(posedge clk) disable iff (clear)
    (legal_o && hold) |=> $stable(state_q));

  // R8: an illegal pattern is replaced by the count-zero pattern
  assert_resync_zero_R8: assert property (@(posedge clk) disable iff (clear)
    !legal_o |=> (state_q == '0));

endmodule

// File: rtl/johnson_decoder.sv
`timescale 1ns/1ps
module johnson_decoder #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES
) (
  input  logic              clk,
  input  logic              clear,
  input  logic [STAGES-1:0] state_i,
  input  logic              legal_i,
  output logic [OUTS-1:0]   dec_o
);

  logic [OUTS-1:0] raw;

  // Each output looks at one pair of neighbouring stages only.
  for (genvar k = 0; k < OUTS; k++) begin : g_dec
    if (k == 0) begin : g_first
      assign raw[k] = ~state_i[0] & ~state_i[STAGES-1];
    end else if (k < STAGES) begin : g_fill
      assign raw[k] = state_i[k-1] & ~state_i[k];
    end else if (k == STAGES) begin : g_full
      assign raw[k] = state_i[STAGES-1] & state_i[0];
    end else begin : g_drain
      assign raw[k] = ~state_i[k-STAGES-1] & state_i[k-STAGES];
    end
  end

  assign dec_o = clear ? '0 : raw;

  // R2: a legal ring decodes to exactly one active output
  assert_one_active_R2: assert property (@(posedge clk) disable iff (clear)
    legal_i |-> $onehot(dec_o));

endmodule

// File: rtl/johnson_decade.sv
`timescale 1ns/1ps
module johnson_decade #(
  parameter int STAGES = 5,
  localparam int OUTS  = 2 * STAGES
) (
  input  logic            clk,
  input  logic            clear,
  input  logic            hold,
  output logic [OUTS-1:0] dec_o,
  output logic            carry_o
);

  logic [STAGES-1:0] ring_state;
  logic              ring_legal;

  johnson_ring #(.STAGES(STAGES)) u_ring (
    .clk     (clk),
    .clear   (clear),
    .hold    (hold),
    .state_o (ring_state),
    .legal_o (ring_legal)
  );

  johnson_decoder #(.STAGES(STAGES)) u_dec (
    .clk     (clk),
    .clear   (clear),
    .state_i (ring_state),
    .legal_i (ring_legal),
    .dec_o   (dec_o)
  );

  // Carry follows the inverse of the last stage: high in the first half.
  assign carry_o = ~ring_state[STAGES-1];

  // R1: an advancing edge moves the active output up by one place
  assert_step_up_R1: assert property (@(posedge clk) disable iff (clear)
    (ring_legal && !hold && !dec_o[OUTS-1]) |=> (dec_o == ($past(dec_o) << 1)));

  // R1: the top output is followed by output zero
  assert_wrap_to_zero_R1: assert property (@(posedge clk) disable iff (clear)
    (ring_legal && !hold && dec_o[OUTS-1]) |=> (dec_o == OUTS'(1)));

  // R4: carry is high exactly in the lower half of the count
  assert_carry_half_R4: assert property (@(posedge clk) disable iff (clear)
    ring_legal |-> (carry_o == (|dec_o[STAGES-1:0])));

  // R4: carry rises on the wrap edge
  assert_carry_rise_R4: assert property (@(posedge clk) disable iff (clear)
    (ring_legal && !hold && dec_o[OUTS-1]) |=> $rose(carry_o));

endmodule

// File: tb/test_johnson_decade.sv
`timescale 1ns/1ps
module test_johnson_decade;

  localparam int S      = 5;
  localparam int N      = 2 * S;
  localparam time HALF  = 10ns;

  logic         clk = 1'b0;
  logic         clear = 1'b1;
  logic         hold = 1'b0;
  logic [N-1:0] dec_o;
  logic         carry_o;
  logic [S-1:0] bad;

  int checks = 0;
  int fails  = 0;
  int ecnt   = 0;
  bit done   = 1'b0;
  int seen [N];

  johnson_decade #(.STAGES(S)) i_johnson_decade (
    .clk     (clk),
    .clear   (clear),
    .hold    (hold),
    .dec_o   (dec_o),
    .carry_o (carry_o)
  );

  always #(HALF) clk = ~clk;

  function automatic logic [N-1:0] exp_dec(input int k);
    return N'(1) << k;
  endfunction

  function automatic logic exp_carry(input int k);
    return (k < S);
  endfunction

  function automatic logic [S-1:0] ring_of(input int k);
    if (k <= S) return S'((1 << k) - 1);
    return S'(((1 << S) - 1) & ~((1 << (k - S)) - 1));
  endfunction

  function automatic bit is_legal(input logic [S-1:0] p);
    for (int k = 0; k < N; k++) if (ring_of(k) == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [N-1:0] got,
                       input logic [N-1:0] want);
    checks++;
    if (got !== want) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, got, want, $time);
    end
  endtask

  task automatic check_outputs(input string req);
    if (clear) begin
      check({req, " dec"}, dec_o, '0);
      check({req, " carry"}, N'(carry_o), N'(1));
    end else begin
      check({req, " dec"}, dec_o, exp_dec(ecnt));
      check({req, " carry"}, N'(carry_o), N'(exp_carry(ecnt)));
    end
  endtask

  // One rising edge, model update, compare at the falling edge.
  task automatic tick(input string req);
    @(posedge clk);
    if (!clear && !hold) ecnt = (ecnt + 1) % N;
    @(negedge clk);
    check_outputs(req);
  endtask

  // Asynchronous clear pulse starting mid-phase, released at a falling edge.
  task automatic clear_pulse;
    #3ns clear = 1'b1;
    #2ns check("R6 async clear dec", dec_o, '0);
    check("R6 async clear carry", N'(carry_o), N'(1));
    @(posedge clk);
    @(negedge clk);
    check("R6 clear held over edge", dec_o, '0);
    clear = 1'b0;
    ecnt  = 0;
    #2ns check("R7 release dec", dec_o, exp_dec(0));
    check("R7 release carry", N'(carry_o), N'(1));
  endtask

  initial begin
    #(HALF * 2 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4017));
    // Reset state with clear held over several edges (R6)
    repeat (3) @(negedge clk);
    check_outputs("R6 reset");
    clear = 1'b0;
    ecnt  = 0;
    #2ns check("R7 first release", dec_o, exp_dec(0));

    // Directed counting through two full cycles (R1, R4)
    for (int i = 0; i < 2 * N; i++) tick("R1 R4 count");

    // Each output active once per ten edges (R3)
    for (int k = 0; k < N; k++) seen[k] = 0;
    for (int i = 0; i < N; i++) begin
      tick("R3 window");
      for (int k = 0; k < N; k++) if (dec_o[k]) seen[k]++;
    end
    for (int k = 0; k < N; k++)
      check("R3 once per ten", N'(seen[k]), N'(1));

    // Hold freezes the count (R5)
    tick("R1 pre-hold");
    hold = 1'b1;
    for (int i = 0; i < 6; i++) tick("R5 hold");
    hold = 1'b0;
    for (int i = 0; i < 3; i++) tick("R1 after hold");

    // Clear mid-cycle (R6, R7)
    clear_pulse();
    for (int i = 0; i < 4; i++) tick("R7 resume");

    // Illegal patterns recover in one edge, even when held (R8)
    for (int v = 0; v < (1 << S); v++) begin
      if (!is_legal(S'(v))) begin
        bad = S'(v);
        hold = 1'b1;
        $assertoff;
        force i_johnson_decade.u_ring.state_q = bad;
        #1ns release i_johnson_decade.u_ring.state_q;
        ecnt = 0;
        tick("R8 resync");
        tick("R8 held after resync");
        hold = 1'b0;
        tick("R8 resume");
        $asserton;
      end
    end

    // Constrained random mix of hold and clear (R1 R2 R4 R5 R6 R7)
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 2) begin
        hold = 1'b0;
        clear_pulse();
      end else begin
        hold = ($urandom % 4) == 0;
        tick("R2 random");
        checks++;
        if (!clear && $countones(dec_o) != 1) begin
          fails++;
          $display("FAIL R2: actual %b expected one-hot", dec_o);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule